// File: doc/BRIEF.md
# Open-Drain Two-Wire Bus Master

This block is a single-master engine for a two-wire serial bus made of a clock line (SCL) and a data line (SDA). It never drives a line high. For each line it has one enable output: when the enable is 1 the pad pulls the line low, and when it is 0 the line is released and an external resistor pulls it high. The pad's output data value is fixed at 0. Both lines are read back through their own inputs. Each input passes through a two-stage synchronizer before any logic samples it.

The caller sends one command at a time over a valid/ready handshake. There are four commands: a start condition, a stop condition, a byte write and a byte read. For a write or a read, the caller picks the bit order of that one byte. For a read, the caller also picks whether the master acknowledges the byte or ends the stream with a not-acknowledge. Every phase of the bus waveform lasts a whole number of quarter bit periods, and the length of a quarter is set on an input pin. After the master releases SCL it waits until it sees the line high before it times the phase. If the line stays low for too long, the command ends with a bus error.

Back-pressure works in one direction only. `cmd_ready` is high only while the engine is idle, and a command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. The caller must hold the command fields steady until that edge. The result comes back with a one-cycle `rsp_done` pulse, which cannot be stalled. The result fields keep their values until the next command completes.

Top module: `odm_master`

## Requirements
- R1: Out of reset, `scl_oe` and `sda_oe` are 0, so both lines are released. `cmd_ready` is 1 and `rsp_done` is 0. An enable of 1 pulls its line low, and the line is never driven high.
- R2: A command is taken when `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` then stays 0 until the command completes. Completion is marked by `rsp_done` high for exactly one cycle.
- R3: One quarter lasts max(`quarter_div`, 4) clock cycles. Inside a byte, each time the master holds SCL low between two clock pulses, it holds it for exactly two quarters.
- R4: During a byte write or read, `sda_oe` changes only while the master is pulling SCL low. A transition on SDA while SCL is high happens only in a start or stop condition.
- R5: The opcode encodings are: start = 0, stop = 1, write = 2, read = 3. Start makes SDA fall while SCL is high, and it may be issued again after a byte as a repeated start. Start ends with the master pulling both lines low. Stop makes SDA rise while SCL is high and ends with both lines released.
- R6: A write shifts out `cmd_data` on eight SCL pulses. It sends bit 0 first when `cmd_lsb_first` is 1 and bit 7 first when it is 0. A write that completes without error leaves SCL pulled low.
- R7: During a write, the master releases SDA for the ninth SCL pulse. `rsp_nack` reports the SDA level sampled on that pulse: 1 means no acknowledge, 0 means acknowledged.
- R8: A read samples SDA on eight pulses and assembles `rsp_data` in the order selected by `cmd_lsb_first`. On the ninth pulse the master releases SDA when `cmd_last` is 1 and pulls it low when `cmd_last` is 0. The read returns `rsp_nack` = 0.
- R9: After releasing SCL, the master waits while the line is still held low by something else on the bus. A wait shorter than `STRETCH_CYC` cycles causes no error, and the transfer then completes with correct data.
- R10: If SCL is still low `STRETCH_CYC` cycles after the master starts waiting, the command ends with `rsp_bus_err` = 1, and the master releases both lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| quarter_div | input | QW | Length of one quarter in cycles; values below 4 are treated as 4 |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 2 | Opcode: 0 start, 1 stop, 2 write, 3 read |
| cmd_data | input | 8 | Byte to write |
| cmd_lsb_first | input | 1 | 1 = bit 0 first, 0 = bit 7 first |
| cmd_last | input | 1 | Read only: 1 = send not-acknowledge |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 8 | Byte read by the last command |
| rsp_nack | output | 1 | Write got no acknowledge |
| rsp_bus_err | output | 1 | SCL failed to rise in time |
| scl_in | input | 1 | Sensed SCL level |
| sda_in | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | 1 = pull SCL low |
| sda_oe | output | 1 | 1 = pull SDA low |

## Verification
A phase counter that has slipped shows up in the length of the SCL low time. It is visible within a single bit, about two quarters after the fault, when a measured low run differs from two quarters. A wrong bit index or a wrong order choice corrupts the byte that the bench's slave model captures, and this is seen when the ninth pulse completes. A state machine that moves SDA at the wrong time is caught at the moment of the edge. A line monitor counts any SDA transition made while SCL is high during a byte as a spurious start or stop. A broken stretch counter shows up one wait window later: either an error is flagged on a short hold, or no error is flagged on a long one.

// File: rtl/odm_pkg.sv
package odm_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } odm_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_STOP  = 2'd2,
    ST_BIT   = 2'd3
  } odm_state_e;

  localparam int unsigned ODM_MIN_QUARTER = 4;
  localparam int unsigned ODM_BITS_PER_BYTE = 8;
endpackage

// File: rtl/odm_sync.sv
module odm_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[s] <= '1;
        else        st[s] <= d;
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[s] <= '1;
        else        st[s] <= st[s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/odm_quarter.sv
module odm_quarter #(
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [QW-1:0] lim,
  input  logic          en,
  input  logic          clr,
  output logic          tick
);
  logic [QW-1:0] qcnt;

  assign tick = en && (qcnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            qcnt <= '0;
    else if (clr || tick)  qcnt <= '0;
    else if (en)           qcnt <= qcnt + 1'b1;
  end
endmodule

// File: rtl/odm_core.sv
module odm_core
  import odm_pkg::*;
#(
  parameter int STRETCH_CYC = 3500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       tick,
  output logic       tick_en,
  output logic       tick_clr,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [1:0] cmd_op,
  input  logic [7:0] cmd_data,
  input  logic       cmd_lsb_first,
  input  logic       cmd_last,
  output logic       rsp_done,
  output logic [7:0] rsp_data,
  output logic       rsp_nack,
  output logic       rsp_bus_err,
  output logic       scl_lo,
  output logic       sda_lo
);
  localparam int SW = $clog2(STRETCH_CYC + 1);
  localparam logic [SW-1:0] SLIM = SW'(STRETCH_CYC - 1);
  localparam logic [3:0] ACK_SLOT = 4'(ODM_BITS_PER_BYTE);

  odm_state_e state;
  logic [1:0] ph;
  logic [3:0] bitn;
  logic       op_rd, lsb, last;
  logic [7:0] dat, rx;
  logic       nack;
  logic [SW-1:0] scnt;

  logic       need_high, wait_scl, stretch_err, tx_bit, fin;
  logic [2:0] pos;

  assign cmd_ready = (state == ST_IDLE);
  assign pos       = lsb ? bitn[2:0] : (3'd7 - bitn[2:0]);

  // the phase in which SCL was just released must see it high before timing
  assign need_high   = (state != ST_IDLE) && (ph == 2'd1);
  assign wait_scl    = need_high && !scl_s;
  assign stretch_err = wait_scl && (scnt == SLIM);
  assign tick_en     = (state != ST_IDLE) && !wait_scl;
  assign tick_clr    = (state == ST_IDLE);

  always_comb begin
    if (bitn == ACK_SLOT) tx_bit = op_rd ? last : 1'b1;
    else                  tx_bit = op_rd ? 1'b1 : dat[pos];
  end

  always_comb begin
    fin = 1'b0;
    case (state)
      ST_START: fin = tick && (ph == 2'd3);
      ST_STOP:  fin = tick && (ph == 2'd2);
      ST_BIT:   fin = tick && (ph == 2'd3) && (bitn == ACK_SLOT);
      default:  fin = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scnt <= '0;
    else if (!wait_scl) scnt <= '0;
    else scnt <= scnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;  ph <= '0;  bitn <= '0;
      op_rd <= 1'b0;  lsb <= 1'b0;  last <= 1'b0;
      dat <= '0;  rx <= '0;  nack <= 1'b0;
      rsp_done <= 1'b0;  rsp_data <= '0;  rsp_nack <= 1'b0;  rsp_bus_err <= 1'b0;
      scl_lo <= 1'b0;  sda_lo <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            ph <= '0;  bitn <= '0;  rx <= '0;  nack <= 1'b0;
            dat <= cmd_data;  lsb <= cmd_lsb_first;  last <= cmd_last;
            op_rd <= (cmd_op == OP_READ);
            case (odm_op_e'(cmd_op))
              OP_START: state <= ST_START;
              OP_STOP:  state <= ST_STOP;
              default:  state <= ST_BIT;
            endcase
          end
        end
        ST_START: begin
          case (ph)
            2'd0: sda_lo <= 1'b0;
            2'd1: scl_lo <= 1'b0;
            2'd2: sda_lo <= 1'b1;
            default: scl_lo <= 1'b1;
          endcase
          if (tick) ph <= ph + 1'b1;
        end
        ST_STOP: begin
          case (ph)
            2'd0: sda_lo <= 1'b1;
            2'd1: scl_lo <= 1'b0;
            default: sda_lo <= 1'b0;
          endcase
          if (tick) ph <= ph + 1'b1;
        end
        default: begin
          case (ph)
            2'd0: sda_lo <= !tx_bit;
            2'd1: scl_lo <= 1'b0;
            2'd2: ;
            default: scl_lo <= 1'b1;
          endcase
          if (tick) begin
            if (ph == 2'd2) begin
              if (bitn == ACK_SLOT) begin
                if (!op_rd) nack <= sda_s;
              end else if (op_rd) begin
                rx[pos] <= sda_s;
              end
            end
            if (ph == 2'd3) begin
              ph   <= '0;
              bitn <= bitn + 1'b1;
            end else begin
              ph <= ph + 1'b1;
            end
          end
        end
      endcase

      if (stretch_err) begin
        state <= ST_IDLE;
        rsp_done <= 1'b1;  rsp_bus_err <= 1'b1;  rsp_nack <= 1'b0;  rsp_data <= rx;
        scl_lo <= 1'b0;  sda_lo <= 1'b0;
      end else if (fin) begin
        state <= ST_IDLE;
        rsp_done <= 1'b1;  rsp_bus_err <= 1'b0;  rsp_nack <= nack;  rsp_data <= rx;
      end
    end
  end
endmodule

// File: rtl/odm_master.sv
module odm_master
  import odm_pkg::*;
#(
  parameter int QW          = 16,
  parameter int STRETCH_CYC = 3500,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [QW-1:0] quarter_div,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [7:0]    cmd_data,
  input  logic          cmd_lsb_first,
  input  logic          cmd_last,
  output logic          rsp_done,
  output logic [7:0]    rsp_data,
  output logic          rsp_nack,
  output logic          rsp_bus_err,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          sda_oe
);
  localparam logic [QW-1:0] QMIN = QW'(ODM_MIN_QUARTER);

  logic [1:0]    line_s;
  logic [QW-1:0] qlim;
  logic          tick, tick_en, tick_clr;

  assign qlim = (quarter_div < QMIN) ? (QMIN - 1'b1) : (quarter_div - 1'b1);

  odm_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(line_s)
  );

  odm_quarter #(.QW(QW)) u_quarter (
    .clk(clk), .rst_n(rst_n), .lim(qlim), .en(tick_en), .clr(tick_clr), .tick(tick)
  );

  odm_core #(.STRETCH_CYC(STRETCH_CYC)) u_core (
    .clk(clk), .rst_n(rst_n),
    .scl_s(line_s[1]), .sda_s(line_s[0]),
    .tick(tick), .tick_en(tick_en), .tick_clr(tick_clr),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_lsb_first(cmd_lsb_first), .cmd_last(cmd_last),
    .rsp_done(rsp_done), .rsp_data(rsp_data), .rsp_nack(rsp_nack),
    .rsp_bus_err(rsp_bus_err),
    .scl_lo(scl_oe), .sda_lo(sda_oe)
  );
endmodule

// File: rtl/odm_master_chk.sv
module odm_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_op,
  input logic       rsp_done,
  input logic       rsp_bus_err,
  input logic       scl_oe,
  input logic       sda_oe
);
  logic       busy;
  logic [1:0] op_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;  op_q <= 2'd0;
    end else if (cmd_valid && cmd_ready) begin
      busy <= 1'b1;  op_q <= cmd_op;
    end else if (rsp_done) begin
      busy <= 1'b0;
    end
  end

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  p_busy_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rsp_done) |-> !cmd_ready);

  p_sda_moves_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q[1] && !rsp_done && (sda_oe != $past(sda_oe))) |-> $past(scl_oe));

  p_scl_left_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && !rsp_bus_err && (op_q != 2'd1)) |-> scl_oe);

  p_stop_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && !rsp_bus_err && (op_q == 2'd1)) |-> (!scl_oe && !sda_oe));

  p_err_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_bus_err) |-> (!scl_oe && !sda_oe));
endmodule

bind odm_master odm_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .rsp_done(rsp_done), .rsp_bus_err(rsp_bus_err),
  .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/tb_odm_master.sv
module tb_odm_master;
  localparam int QW  = 16;
  localparam int STR = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [QW-1:0] quarter_div = 16'd4;
  logic cmd_valid = 1'b0, cmd_lsb_first = 1'b0, cmd_last = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_data = 8'h00;
  logic cmd_ready, rsp_done, rsp_nack, rsp_bus_err, scl_oe, sda_oe;
  logic [7:0] rsp_data;

  logic slv_scl_hold = 1'b0, slv_sda_low;
  logic scl_line, sda_line;
  assign scl_line = !(scl_oe || slv_scl_hold);
  assign sda_line = !(sda_oe || slv_sda_low);

  odm_master #(.QW(QW), .STRETCH_CYC(STR)) dut (
    .clk(clk), .rst_n(rst_n), .quarter_div(quarter_div),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_lsb_first(cmd_lsb_first), .cmd_last(cmd_last),
    .rsp_done(rsp_done), .rsp_data(rsp_data), .rsp_nack(rsp_nack),
    .rsp_bus_err(rsp_bus_err), .scl_in(scl_line), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int total = 0, bad = 0, tm_total = 0, tm_bad = 0;
  int cyc = 0, acc_t = 0, rise_t = 0, qexp = 4;
  int nfall = 0, base = 0, n_start = 0, n_stop = 0, n_glitch = 0;
  int mode = 0;            // 0 idle, 1 write slave, 2 read slave
  logic ack_en = 1'b1, in_byte = 1'b0, tx_lsb = 1'b0, prev_oe = 1'b0;
  logic [7:0] tx = 8'h00;
  logic [8:0] cap = '0;
  int kk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // slave model
  always @(negedge scl_line) nfall <= nfall + 1;
  always_comb begin
    kk = nfall - base;
    slv_sda_low = 1'b0;
    if (mode == 1) slv_sda_low = ack_en && (kk == 8);
    else if (mode == 2 && kk >= 0 && kk < 8)
      slv_sda_low = !(tx_lsb ? tx[kk] : tx[7-kk]);
  end
  always @(posedge scl_line) begin
    if ((nfall - base) >= 0 && (nfall - base) < 9) cap[nfall - base] <= sda_line;
  end
  always @(negedge sda_line) if (scl_line) begin n_start++; if (in_byte) n_glitch++; end
  always @(posedge sda_line) if (scl_line) begin n_stop++; if (in_byte) n_glitch++; end

  // R3 low-run timing monitor
  always @(negedge clk) begin
    cyc++;
    if (scl_oe && !prev_oe) rise_t = cyc;
    if (!scl_oe && prev_oe && in_byte && rise_t > acc_t) begin
      tm_total++;
      if (cyc - rise_t != 2 * qexp) begin
        tm_bad++;
        $display("FAIL R3 scl low run actual=%0d expected=%0d", cyc - rise_t, 2 * qexp);
      end
    end
    prev_oe = scl_oe;
  end

  task automatic issue(input logic [1:0] op, input logic [7:0] d, input logic lsb, input logic lst);
    @(negedge clk);
    cmd_op = op; cmd_data = d; cmd_lsb_first = lsb; cmd_last = lst; cmd_valid = 1'b1;
    acc_t = cyc; base = nfall;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!rsp_done && n < 20000) begin @(negedge clk); n++; end
    chk(rsp_done, "R2 done seen", rsp_done, 1);
  endtask

  task automatic run(input logic [1:0] op, input logic [7:0] d, input logic lsb, input logic lst);
    in_byte = op[1];
    issue(op, d, lsb, lst);
    chk(!cmd_ready || rsp_done, "R2 ready low while busy", cmd_ready, 0);
    wait_done();
    @(negedge clk);
    chk(!rsp_done, "R2 done one cycle", rsp_done, 0);
    in_byte = 1'b0;
  endtask

  initial begin
    #2_000_000;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total + tm_total + 1, bad + tm_bad + 1);
    $finish;
  end

  initial begin
    int s0, p0;
    logic [7:0] b, rb;
    repeat (3) @(negedge clk);
    chk(!scl_oe && !sda_oe, "R1 lines released at reset", {scl_oe, sda_oe}, 0);
    chk(cmd_ready && !rsp_done, "R1 ready at reset", {cmd_ready, rsp_done}, 2);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    foreach (qexp_list[qi]) begin end
    for (int qi = 0; qi < 3; qi++) begin
      quarter_div = (qi == 0) ? 16'd1 : (qi == 1) ? 16'd5 : 16'd7;
      qexp = (quarter_div < 4) ? 4 : int'(quarter_div);
      s0 = n_start;
      mode = 0; run(2'd0, 8'h00, 1'b0, 1'b0);
      chk(n_start == s0 + 1, "R5 start edge", n_start - s0, 1);
      chk(scl_oe && sda_oe, "R5 start leaves lines low", {scl_oe, sda_oe}, 3);
      for (int i = 0; i < 32; i++) begin
        b = 8'((i * 37 + 5 + qi * 11) & 255);
        ack_en = (i % 3) != 0;
        mode = 1;
        run(2'd2, b, i[0], 1'b0);
        for (int k = 0; k < 8; k++) begin
          if (i[0]) rb[k] = cap[k]; else rb[7-k] = cap[k];
        end
        chk(rb == b, "R6 written byte order", rb, b);
        chk(rsp_nack == !ack_en, "R7 ack status", rsp_nack, !ack_en);
        chk(scl_oe, "R6 scl left low", scl_oe, 1);
      end
      for (int i = 0; i < 16; i++) begin
        tx = 8'((i * 53 + 29 + qi) & 255);
        tx_lsb = i[1];
        mode = 2;
        run(2'd3, 8'h00, tx_lsb, i[0]);
        chk(rsp_data == tx, "R8 read data", rsp_data, tx);
        chk(cap[8] == i[0], "R8 ack slot level", cap[8], i[0]);
        chk(!rsp_nack, "R8 read nack flag", rsp_nack, 0);
      end
      s0 = n_start;
      mode = 0; run(2'd0, 8'h00, 1'b0, 1'b0);
      chk(n_start == s0 + 1, "R5 repeated start", n_start - s0, 1);
      p0 = n_stop;
      run(2'd1, 8'h00, 1'b0, 1'b0);
      chk(n_stop == p0 + 1, "R5 stop edge", n_stop - p0, 1);
      chk(!scl_oe && !sda_oe, "R5 stop releases", {scl_oe, sda_oe}, 0);
    end
    chk(n_glitch == 0, "R4 no SDA edge with SCL high in bytes", n_glitch, 0);
    chk(tm_total > 0, "R3 runs measured", tm_total, 1);

    // R9 short stretch
    quarter_div = 16'd4; qexp = 4;
    mode = 0; run(2'd0, 8'h00, 1'b0, 1'b0);
    mode = 1; ack_en = 1'b1; in_byte = 1'b1; slv_scl_hold = 1'b1;
    issue(2'd2, 8'hA6, 1'b0, 1'b0);
    repeat (STR - 10) @(negedge clk);
    slv_scl_hold = 1'b0;
    wait_done();
    chk(!rsp_bus_err, "R9 short hold no error", rsp_bus_err, 0);
    for (int k = 0; k < 8; k++) rb[7-k] = cap[k];
    chk(rb == 8'hA6, "R9 data after stretch", rb, 8'hA6);
    @(negedge clk); in_byte = 1'b0;

    // R10 long hold
    slv_scl_hold = 1'b1; in_byte = 1'b1;
    issue(2'd2, 8'h3C, 1'b1, 1'b0);
    s0 = cyc;
    wait_done();
    chk(rsp_bus_err, "R10 bus error flagged", rsp_bus_err, 1);
    chk(cyc - s0 >= STR, "R10 error not early", cyc - s0, STR);
    @(negedge clk);
    chk(!scl_oe && !sda_oe, "R10 lines released", {scl_oe, sda_oe}, 0);
    in_byte = 1'b0; mode = 0; slv_scl_hold = 1'b0;
    repeat (5) @(negedge clk);
    chk(cmd_ready, "R10 ready after error", cmd_ready, 1);

    $display("test done: total=%0d bad=%0d", total + tm_total, bad + tm_bad);
    $finish;
  end

  int qexp_list[1];
endmodule